// File: doc/BRIEF.md
# Byte SPI Port with Master Contention Guard

This block is a byte-wide serial peripheral port that can act as the clocking side or the clocked side of a link. A host reaches it through a small register interface with three locations: control, status and data. It has four serial pins: clock, master-out, master-in and an active-low select. In master mode, writing the data location sends one byte while receiving one, using a clock made by dividing the system clock. In slave mode, the port shifts under a clock supplied from outside and places each finished byte in the data location. If the host leaves that byte unread when the next one arrives, the port flags an overrun.

A master that sees its select input pulled low assumes another master is driving the bus. It then leaves master mode, disables itself, releases its clock and data outputs, and raises a sticky fault flag. All serial data moves most-significant bit first. The clock idles low. Outputs change on the falling clock edge and inputs are sampled on the rising clock edge. In slave mode, the clock, select and master-out inputs pass through two-stage synchronizers before any edge is detected.

Register map (the address is `reg_addr`):
- 0, control: bit0 enable, bit1 master, bits3:2 divider select.
- 1, status: bit7 done, bit6 overrun, bit4 fault.
- 2, data.
- 3 reads as zero.

Top module: `spi_port`

## Requirements
- R1: Control bit1 selects master (1) or slave (0), and bit0 enables the port. Control reads back {4'b0, div, master, enable}. In master mode `sck_oe` and `mosi_oe` are high. In slave mode they are low.
- R2: In master mode, a data write when the port is idle sends that byte MSB first on `mosi_o` while 8 bits are taken from `miso_i`. `mosi_o` changes on falling `sck_o` edges and `miso_i` is sampled on rising edges. `sck_o` is low whenever no transfer is running.
- R3: Each half period of `sck_o` lasts 2^(div+1) system clocks, where div is control bits3:2. With div=2 the full period is 16 clocks.
- R4: When the eighth bit has been sampled, status bit7 (done) sets and the received byte appears at the data location. Reading the data location clears done.
- R5: A data write while a master transfer is running is ignored. The running byte completes unchanged.
- R6: In slave mode with `ss_n_i` low, each rising edge of `sck_i` shifts `mosi_i` in. After the eighth edge the byte is placed in the data location and done sets.
- R7: In slave mode, a data write while `ss_n_i` is high preloads the outgoing byte. That byte appears on `miso_o` MSB first, changing on falling `sck_i` edges. `miso_oe` is high only while the port is an enabled slave with `ss_n_i` low.
- R8: While the port is a slave, `ss_n_i` high resets the bit count, so partial bits received before it are discarded.
- R9: If a slave byte completes while done is still set, the stored byte is kept, the new byte is dropped and status bit6 (overrun) sets. Overrun clears only when status is read with it set and the data location is read afterwards.
- R10: A data read in the same cycle that a slave byte completes counts as reading in time. The read returns the old byte, the new byte is stored, done stays set and no overrun is flagged.
- R11: In master mode, `ss_n_i` low clears the enable and master bits, aborts any transfer, sets status bit4 (fault) and drops `sck_oe` and `mosi_oe`.
- R12: The fault bit stays set, even after `ss_n_i` returns high, until the host writes status with bit4 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Enable for the serial clock driver |
| mosi_i | input | 1 | Master-out line as seen by a slave |
| mosi_o | output | 1 | Master-out data driven by the master |
| mosi_oe | output | 1 | Enable for the master-out driver |
| miso_i | input | 1 | Master-in line as seen by the master |
| miso_o | output | 1 | Master-in data driven by the slave |
| miso_oe | output | 1 | Enable for the master-in driver |
| ss_n_i | input | 1 | Active-low select input |

## Verification
The delicate coincidence is a host read of the data location landing in the very cycle that a slave byte completes. That cycle decides whether the byte counts as overrun or as consumed. The bench counts the synchronizer stages: it raises the last external clock edge, waits two system clocks, then asserts the read strobe so that it meets the completion edge. It then judges the outcome from the returned old byte, the new stored byte, and a status showing done without overrun. A second coincidence, a select fault arriving during a master transfer, is judged by checking that done never sets.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int SEL_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       ss_n_i
);
  localparam int CNT_W = (1 << SEL_W) + 1;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  logic             en_q, mst_q, modf_q, done_q, ovr_q, arm_q;
  logic [SEL_W-1:0] div_q;
  logic [7:0]       data_q, sh_q;
  logic [3:0]       bit_q;
  logic             out_q, busy_q, sck_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       sck_s, ss_s;
  logic [1:0]       mosi_s;

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire wr_stat = reg_wr && reg_addr == A_STAT;
  wire wr_data = reg_wr && reg_addr == A_DATA;
  wire rd_stat = reg_rd && reg_addr == A_STAT;
  wire rd_data = reg_rd && reg_addr == A_DATA;

  wire master = en_q && mst_q;
  wire slave  = en_q && !mst_q;
  wire ss_low = !ss_s[1];
  wire fault  = master && ss_low;
  wire s_rise = sck_s[1] && !sck_s[2];
  wire s_fall = !sck_s[1] && sck_s[2];
  wire last   = bit_q == 4'd7;
  wire tick   = busy_q && cnt_q == '0;

  wire [CNT_W-1:0] half_m1 = (CNT_W'(2) << div_q) - CNT_W'(1);
  wire [7:0]       sh_next = {sh_q[6:0], master ? miso_i : mosi_s[1]};

  wire m_done   = master && !fault && tick && !sck_q && last;
  wire s_done   = slave && ss_low && s_rise && last;
  wire complete = m_done || s_done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s  <= 3'b000;
      ss_s   <= 3'b111;
      mosi_s <= 2'b00;
    end else begin
      sck_s  <= {sck_s[1:0], sck_i};
      ss_s   <= {ss_s[1:0], ss_n_i};
      mosi_s <= {mosi_s[0], mosi_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q   <= 1'b0;
      mst_q  <= 1'b0;
      div_q  <= '0;
      modf_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata[0];
        mst_q <= reg_wdata[1];
        div_q <= reg_wdata[SEL_W+1:2];
      end
      if (wr_stat && reg_wdata[4]) modf_q <= 1'b0;
      if (fault) begin
        en_q   <= 1'b0;
        mst_q  <= 1'b0;
        modf_q <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      out_q  <= 1'b0;
    end else if (master && !fault) begin
      if (busy_q) begin
        if (tick) begin
          cnt_q <= half_m1;
          sck_q <= !sck_q;
          if (!sck_q) begin
            sh_q  <= sh_next;
            bit_q <= bit_q + 4'd1;
          end else if (bit_q == 4'd8) begin
            busy_q <= 1'b0;
          end else begin
            out_q <= sh_q[7];
          end
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end else if (wr_data) begin
        busy_q <= 1'b1;
        sh_q   <= reg_wdata;
        out_q  <= reg_wdata[7];
        bit_q  <= '0;
        cnt_q  <= half_m1;
        sck_q  <= 1'b0;
      end
    end else begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      if (slave) begin
        if (!ss_low) begin
          bit_q <= '0;
          if (wr_data) begin
            sh_q  <= reg_wdata;
            out_q <= reg_wdata[7];
          end else begin
            out_q <= sh_q[7];
          end
        end else if (s_rise) begin
          sh_q  <= sh_next;
          bit_q <= last ? 4'd0 : bit_q + 4'd1;
        end else if (s_fall) begin
          out_q <= sh_q[7];
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      arm_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (rd_stat && ovr_q) arm_q <= 1'b1;
      if (rd_data) begin
        done_q <= 1'b0;
        if (arm_q) begin
          ovr_q <= 1'b0;
          arm_q <= 1'b0;
        end
      end
      if (wr_data && master && !busy_q) done_q <= 1'b0;
      if (complete) begin
        if (done_q && !rd_data) begin
          ovr_q <= 1'b1;
        end else begin
          data_q <= sh_next;
          done_q <= 1'b1;
        end
      end
    end

  always_comb
    case (reg_addr)
      A_CTRL:  reg_rdata = 8'({div_q, mst_q, en_q});
      A_STAT:  reg_rdata = {done_q, ovr_q, 1'b0, modf_q, 4'b0};
      A_DATA:  reg_rdata = data_q;
      default: reg_rdata = '0;
    endcase

  assign sck_o   = sck_q;
  assign sck_oe  = master;
  assign mosi_o  = out_q;
  assign mosi_oe = master;
  assign miso_o  = out_q;
  assign miso_oe = slave && ss_low;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy_q |-> !sck_q); // R2
  AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) bit_q <= 4'd8); // R2
  AST_DONE_ON_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(done_q) |-> $past(bit_q) == 4'd7); // R4
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovr_q) |-> $stable(data_q)); // R9
  AST_FAULT_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n) $rose(modf_q) |-> !en_q && !mst_q && !busy_q); // R11
  AST_MODF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) modf_q && !(wr_stat && reg_wdata[4]) |=> modf_q); // R12
endmodule

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic sck_i = 0, mosi_i = 0, ss_n_i = 1;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_i, miso_o, miso_oe;
  logic [7:0] tb_tx = 0, tb_rx = 0;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  spi_port dut (.*);

  assign miso_i = tb_tx[7];
  always @(posedge sck_o) tb_rx <= {tb_rx[6:0], mosi_o};
  always @(negedge sck_o) tb_tx <= {tb_tx[6:0], 1'b0};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic slave_bits(input logic [7:0] b, input int n, output logic [7:0] seen);
    seen = 0;
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); mosi_i = b[i];
      repeat (8) @(negedge clk);
      seen[i] = miso_o;
      sck_i = 1;
      repeat (8) @(negedge clk);
      sck_i = 0;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    bus_rd(0, d); chk(d == 0, "R1 reset ctrl", d, 0);
    bus_rd(1, d); chk(d == 0, "R4 reset status", d, 0);
    chk({sck_oe, mosi_oe, miso_oe} == 0, "R11 reset outputs released", {sck_oe, mosi_oe, miso_oe}, 0);
  endtask

  task automatic t_master_basic;
    logic [7:0] d;
    bus_wr(0, 8'h03);
    bus_rd(0, d); chk(d == 8'h03, "R1 ctrl readback", d, 8'h03);
    chk(sck_oe && mosi_oe && !miso_oe, "R1 master drivers", {sck_oe, mosi_oe, miso_oe}, 3'b110);
    tb_tx = 8'h3C;
    bus_wr(2, 8'hA5);
    repeat (60) @(negedge clk);
    chk(tb_rx == 8'hA5, "R2 mosi MSB first", tb_rx, 8'hA5);
    chk(sck_o == 0, "R2 sck idle low", sck_o, 0);
    bus_rd(1, d); chk(d == 8'h80, "R4 done set", d, 8'h80);
    bus_rd(2, d); chk(d == 8'h3C, "R4 received byte", d, 8'h3C);
    bus_rd(1, d); chk(d == 8'h00, "R4 done cleared by read", d, 0);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] d;
    tb_tx = 8'h81;
    bus_wr(2, 8'h5A);
    repeat (4) @(negedge clk);
    bus_wr(2, 8'hFF);
    repeat (60) @(negedge clk);
    chk(tb_rx == 8'h5A, "R5 write during transfer ignored", tb_rx, 8'h5A);
    bus_rd(2, d); chk(d == 8'h81, "R5 received byte intact", d, 8'h81);
  endtask

  task automatic t_divider;
    int n = 0;
    bus_wr(0, 8'h0B);
    tb_tx = 8'h00;
    bus_wr(2, 8'h11);
    do @(negedge clk); while (!sck_o);
    do begin @(negedge clk); n++; end while (sck_o);
    do begin @(negedge clk); n++; end while (!sck_o);
    chk(n == 16, "R3 sck period div=2", n, 16);
    repeat (200) @(negedge clk);
    chk(tb_rx == 8'h11, "R3 transfer at slow clock", tb_rx, 8'h11);
    bus_wr(0, 8'h03);
  endtask

  task automatic t_slave;
    logic [7:0] d, seen;
    bus_wr(0, 8'h01);
    bus_rd(2, d);
    bus_wr(2, 8'h96);
    chk(!sck_oe && !mosi_oe && !miso_oe, "R7 slave outputs off while unselected", {sck_oe, mosi_oe, miso_oe}, 0);
    @(negedge clk); ss_n_i = 0;
    repeat (4) @(negedge clk);
    chk(miso_oe == 1, "R7 miso driven when selected", miso_oe, 1);
    slave_bits(8'h3B, 8, seen);
    chk(seen == 8'h96, "R7 slave transmit MSB first", seen, 8'h96);
    bus_rd(1, d); chk(d == 8'h80, "R6 slave done", d, 8'h80);
    bus_rd(2, d); chk(d == 8'h3B, "R6 slave received byte", d, 8'h3B);
    ss_n_i = 1; repeat (4) @(negedge clk);
  endtask

  task automatic t_ss_reset;
    logic [7:0] d, seen;
    ss_n_i = 0; repeat (4) @(negedge clk);
    slave_bits(8'hE0, 3, seen);
    ss_n_i = 1; repeat (6) @(negedge clk);
    ss_n_i = 0; repeat (4) @(negedge clk);
    slave_bits(8'h4D, 8, seen);
    bus_rd(2, d); chk(d == 8'h4D, "R8 select high resets bit count", d, 8'h4D);
  endtask

  task automatic t_overrun;
    logic [7:0] d, seen;
    slave_bits(8'h21, 8, seen);
    slave_bits(8'h42, 8, seen);
    bus_rd(1, d); chk(d == 8'hC0, "R9 overrun flagged", d, 8'hC0);
    bus_rd(2, d); chk(d == 8'h21, "R9 first byte kept", d, 8'h21);
    bus_rd(1, d); chk(d == 8'h00, "R9 overrun cleared by status then data", d, 0);
  endtask

  task automatic t_same_cycle;
    logic [7:0] d, seen;
    slave_bits(8'h6C, 8, seen);
    slave_bits(8'h93, 7, seen);
    @(negedge clk); mosi_i = 1'b1;
    repeat (8) @(negedge clk);
    sck_i = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    reg_addr = 2; reg_rd = 1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
    chk(d == 8'h6C, "R10 read returns old byte", d, 8'h6C);
    repeat (8) @(negedge clk); sck_i = 0;
    repeat (8) @(negedge clk);
    bus_rd(1, d); chk(d == 8'h80, "R10 no overrun, done set", d, 8'h80);
    bus_rd(2, d); chk(d == 8'h93, "R10 new byte stored", d, 8'h93);
    ss_n_i = 1; repeat (4) @(negedge clk);
  endtask

  task automatic t_mode_fault;
    logic [7:0] d;
    bus_wr(0, 8'h03);
    tb_tx = 8'h00;
    bus_wr(2, 8'hF0);
    repeat (10) @(negedge clk);
    ss_n_i = 0;
    repeat (6) @(negedge clk);
    chk(!sck_oe && !mosi_oe, "R11 drivers released", {sck_oe, mosi_oe}, 0);
    bus_rd(0, d); chk(d[1:0] == 0, "R11 enable and master cleared", d[1:0], 0);
    bus_rd(1, d); chk(d == 8'h10, "R11 fault set, no done", d, 8'h10);
    ss_n_i = 1; repeat (60) @(negedge clk);
    bus_rd(1, d); chk(d == 8'h10, "R12 fault sticky", d, 8'h10);
    bus_wr(1, 8'h10);
    bus_rd(1, d); chk(d == 8'h00, "R12 fault cleared by write", d, 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_master_basic();
    t_busy_ignore();
    t_divider();
    t_slave();
    t_ss_reset();
    t_overrun();
    t_same_cycle();
    t_mode_fault();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule